// File: doc/BRIEF.md
# Sensorless Motor Start-Up Sequencer

This block brings a three-phase motor without position sensors from rest to closed-loop commutation. After reset it passes through three modes in a fixed order: align, ramp and run. In align it holds the commutation machine in its alignment state, so the rotor settles at a known angle. In ramp it runs an open-loop commutation-rate generator whose step rate rises at a constant acceleration. In run it releases commutation to the back-EMF tracking loop.

A free-running `tick` input sets the time base. The align and ramp lengths are counted in ticks, and the rate generator advances once per tick. The ramp rate comes from a phase accumulator. A frequency word is added to the accumulator on every ramp tick. The carry out of that addition is the commutation step. After each addition the frequency word grows by a fixed increment until it reaches a ceiling. All configuration inputs are captured while reset is held and are ignored afterwards.

Top module: `motor_start_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters align. After that edge `mode` is 2'b00, `comm_hold` is 1, `bemf_en` is 0, the accumulator is 0 and both timers are 0. The `mode` encoding is 2'b00 align, 2'b01 ramp and 2'b10 run. The value 2'b11 never appears.
- R2: Align lasts max(`align_len`,1) ticks, and then `mode` becomes ramp. A cycle with `tick` low changes nothing.
- R3: Ramp lasts max(`ramp_len`,1) ticks, and then `mode` becomes run. Run holds until the next reset, and the modes never go backwards.
- R4: On each ramp tick, the frequency word F is added to the accumulator A, which is ACC_W bits wide and wraps modulo 2^ACC_W. `comm_step` is high in that cycle exactly when the addition A+F carries out, which is when A+F >= 2^ACC_W. On ramp entry A is 0 and F is min(`rate_min`,`rate_max`).
- R5: After each ramp tick, F becomes min(F+`rate_inc`, `rate_max`). The sum is computed one bit wider, so F saturates at the ceiling and never wraps.
- R6: `bemf_en` is 0 in align and in ramp, and 1 in run.
- R7: `comm_hold` is 1 in align and 0 in ramp and in run.
- R8: `comm_step` is 0 outside ramp and in every cycle where `tick` is low.
- R9: `align_len`, `ramp_len`, `rate_min`, `rate_inc` and `rate_max` are sampled only while `rst_n` is low. Later changes to these inputs have no effect.
- R10: A reset in the middle of the sequence, including during ramp or run, restarts it from align with the values present during that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; also loads the configuration |
| tick | input | 1 | Time-base enable; timers and the rate generator advance only when it is high |
| align_len | input | LEN_W | Align duration in ticks |
| ramp_len | input | LEN_W | Ramp duration in ticks |
| rate_min | input | ACC_W | Starting frequency word |
| rate_inc | input | ACC_W | Frequency word increment per ramp tick |
| rate_max | input | ACC_W | Frequency word ceiling |
| mode | output | 2 | 00 align, 01 ramp, 10 run |
| comm_hold | output | 1 | Holds the commutation machine in its alignment state |
| bemf_en | output | 1 | Enables back-EMF sampling |
| comm_step | output | 1 | Open-loop commutation strobe during ramp |

## Verification
The hardest situation to reach is a ramp in which the frequency word hits its ceiling, while accumulator carries land on sparse ticks and a reset arrives in the middle of the ramp. Only `comm_step` shows the accumulator and the frequency word at the ports, so the bench cannot observe them directly. Instead it compares every strobe cycle against an arithmetic model of the accumulator. The stimulus sweeps align and ramp lengths, increments and tick densities, and adds a reset in mid-sequence. Further cases cover a starting word above the ceiling and an increment that would overflow the word width. Each configuration is followed by scrambled configuration inputs, so any late sampling shows up as a timing mismatch.

// File: rtl/motor_start_seq.sv
`timescale 1ns/1ps
module motor_start_seq #(
  parameter int LEN_W = 16,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [LEN_W-1:0] align_len,
  input  logic [LEN_W-1:0] ramp_len,
  input  logic [ACC_W-1:0] rate_min,
  input  logic [ACC_W-1:0] rate_inc,
  input  logic [ACC_W-1:0] rate_max,
  output logic [1:0]       mode,
  output logic             comm_hold,
  output logic             bemf_en,
  output logic             comm_step
);
  localparam logic [1:0] M_ALIGN = 2'd0;
  localparam logic [1:0] M_RAMP  = 2'd1;
  localparam logic [1:0] M_RUN   = 2'd2;

  logic [LEN_W-1:0] align_c, ramp_c, cnt;
  logic [ACC_W-1:0] inc_c, max_c, acc, fw;

  logic [LEN_W-1:0] len_now;
  logic [LEN_W:0]   cnt_nx;
  logic             last;
  logic [ACC_W:0]   acc_sum, fw_sum;
  logic [ACC_W-1:0] fw_nx;

  assign len_now = (mode == M_ALIGN) ? align_c : ramp_c;
  assign cnt_nx  = {1'b0, cnt} + {{LEN_W{1'b0}}, 1'b1};
  assign last    = cnt_nx >= {1'b0, len_now};
  assign acc_sum = {1'b0, acc} + {1'b0, fw};
  assign fw_sum  = {1'b0, fw} + {1'b0, inc_c};
  assign fw_nx   = (fw_sum > {1'b0, max_c}) ? max_c : fw_sum[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_ALIGN;
      cnt     <= '0;
      acc     <= '0;
      fw      <= (rate_min > rate_max) ? rate_max : rate_min;
      align_c <= align_len;
      ramp_c  <= ramp_len;
      inc_c   <= rate_inc;
      max_c   <= rate_max;
    end else if (tick) begin
      case (mode)
        M_ALIGN: begin
          if (last) begin
            mode <= M_RAMP;
            cnt  <= '0;
          end else begin
            cnt <= cnt_nx[LEN_W-1:0];
          end
        end
        M_RAMP: begin
          acc <= acc_sum[ACC_W-1:0];
          fw  <= fw_nx;
          if (last) begin
            mode <= M_RUN;
            cnt  <= '0;
          end else begin
            cnt <= cnt_nx[LEN_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  assign comm_hold = (mode == M_ALIGN);
  assign bemf_en   = (mode == M_RUN);
  assign comm_step = tick & (mode == M_RAMP) & acc_sum[ACC_W];
endmodule

module motor_start_seq_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       mode,
  input logic             comm_hold,
  input logic             bemf_en,
  input logic             comm_step,
  input logic [ACC_W-1:0] fw,
  input logic [ACC_W-1:0] max_c
);
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
  a_r2_align_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (mode == 2'b00 || mode == 2'b01));
  a_r2_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mode));
  a_r3_no_return: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |=> (mode != 2'b00));
  a_r3_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (mode == 2'b10));
  a_r5_fw_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fw <= max_c);
  a_r6_bemf_off_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> !bemf_en);
  a_r7_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
    comm_hold |-> (!bemf_en && !comm_step));
  a_r8_step_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    comm_step |-> (mode == 2'b01 && tick));
endmodule

bind motor_start_seq motor_start_seq_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
  .comm_hold(comm_hold), .bemf_en(bemf_en), .comm_step(comm_step),
  .fw(fw), .max_c(max_c)
);

// File: tb/sim_motor_start_seq.sv
`timescale 1ns/1ps
module sim_motor_start_seq;
  localparam int LW = 8;
  localparam int AW = 8;
  localparam int MOD = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic [LW-1:0] align_len = 0, ramp_len = 0;
  logic [AW-1:0] rate_min = 0, rate_inc = 0, rate_max = 0;
  logic [1:0] mode;
  logic comm_hold, bemf_en, comm_step;

  motor_start_seq #(.LEN_W(LW), .ACC_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .align_len(align_len), .ramp_len(ramp_len),
    .rate_min(rate_min), .rate_inc(rate_inc), .rate_max(rate_max),
    .mode(mode), .comm_hold(comm_hold), .bemf_en(bemf_en), .comm_step(comm_step)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit chk_en = 0;
  bit d_rst = 0;
  int d_al = 0, d_rl = 0, d_mn = 0, d_inc = 0, d_mx = 0;
  int m_mode = 0, m_cnt = 0, m_acc = 0, m_fw = 0;
  int c_al = 0, c_rl = 0, c_inc = 0, c_mx = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit t);
    int e_step;
    @(negedge clk);
    rst_n = d_rst; tick = t;
    align_len = d_al[LW-1:0]; ramp_len = d_rl[LW-1:0];
    rate_min = d_mn[AW-1:0]; rate_inc = d_inc[AW-1:0]; rate_max = d_mx[AW-1:0];
    #1;
    if (chk_en) begin
      e_step = (t && m_mode == 1 && (m_acc + m_fw) >= MOD) ? 1 : 0;
      chk("R2 R3 R9 R10 mode", int'(mode), m_mode);
      chk("R7 comm_hold", int'(comm_hold), (m_mode == 0) ? 1 : 0);
      chk("R6 bemf_en", int'(bemf_en), (m_mode == 2) ? 1 : 0);
      chk("R4 R5 R8 comm_step", int'(comm_step), e_step);
    end
    @(posedge clk);
    if (!d_rst) begin
      m_mode = 0; m_cnt = 0; m_acc = 0;
      c_al = d_al; c_rl = d_rl; c_inc = d_inc; c_mx = d_mx;
      m_fw = (d_mn > d_mx) ? d_mx : d_mn;
    end else if (t) begin
      if (m_mode == 0) begin
        if (m_cnt + 1 >= c_al) begin m_mode = 1; m_cnt = 0; end
        else m_cnt++;
      end else if (m_mode == 1) begin
        m_acc = (m_acc + m_fw) % MOD;
        m_fw = (m_fw + c_inc > c_mx) ? c_mx : m_fw + c_inc;
        if (m_cnt + 1 >= c_rl) begin m_mode = 2; m_cnt = 0; end
        else m_cnt++;
      end
    end
  endtask

  function automatic bit tick_of(input int tm, input int i);
    case (tm)
      0: return 1'b1;
      1: return (i % 2) == 0;
      default: return (i % 3) == 1;
    endcase
  endfunction

  task automatic run_cfg(input int al, input int rl, input int mn, input int inc,
                         input int mx, input int tm, input int n, input int rst_at);
    d_rst = 0; d_al = al; d_rl = rl; d_mn = mn; d_inc = inc; d_mx = mx;
    cycle(1'b1);
    cycle(1'b0);
    d_rst = 1;
    d_al = (al ^ 8'h5a) & 8'hff; d_rl = (rl + 77) & 8'hff;
    d_mn = (mn ^ 8'hff); d_inc = (inc + 99) & 8'hff; d_mx = (mx ^ 8'h33);
    @(negedge clk); #2;
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset hold", int'(comm_hold), 1);
    chk("R1 reset bemf", int'(bemf_en), 0);
    for (int i = 0; i < n; i++) begin
      if (rst_at >= 0 && i == rst_at) begin
        d_rst = 0; d_al = al; d_rl = rl; d_mn = mn; d_inc = inc; d_mx = mx;
      end
      if (rst_at >= 0 && i == rst_at + 2) d_rst = 1;
      cycle(tick_of(tm, i));
    end
  endtask

  initial begin
    int als[3] = '{0, 1, 3};
    int rls[3] = '{1, 4, 9};
    int incs[3] = '{0, 7, 40};
    d_rst = 0;
    cycle(1'b0);
    cycle(1'b0);
    chk_en = 1;
    foreach (als[a]) foreach (rls[r]) foreach (incs[k])
      run_cfg(als[a], rls[r], 20, incs[k], 200, (a + r + k) % 3, 50, -1);
    run_cfg(2, 20, 250, 10, 100, 0, 40, -1);
    run_cfg(1, 30, 200, 200, 255, 1, 80, -1);
    run_cfg(0, 0, 130, 0, 255, 0, 10, -1);
    run_cfg(2, 60, 5, 3, 180, 2, 200, -1);
    run_cfg(2, 25, 60, 30, 220, 0, 60, 12);
    run_cfg(1, 3, 60, 30, 220, 0, 40, 20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule